// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Controller

This block decides which interrupt source the processor services next and keeps track of nested services. Each of seven sources has a request line, an enable bit and a 2-bit priority level. Levels run from 0 (lowest) to 3 (highest). At each instruction boundary the controller picks the best enabled pending request. It takes that request only when its level is strictly above every level now being serviced, so a higher-level request preempts a lower-level routine.

The controller keeps one in-service flag per level. Taking an interrupt sets the flag of the winner's level. Each return-from-interrupt clears only the highest flag that is set. This keeps the nesting correct when several levels arrive close together and nest three or four deep, so lower levels can still be serviced after the nest unwinds.

Every vector lies in the top 64K region (0xFF:). The address is absolute and does not depend on the region the processor is executing from. Clearing the request flags inside the peripherals is left to the peripherals.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irq_take` is 0, `lvl_busy` is 0000, `act_level` is 0 and `vec_addr` is 0xFF0000.
- R2: Arbitration happens only in a cycle with `insn_bnd`=1 and `glb_en`=1. An accepted request raises `irq_take` for exactly one cycle, in the cycle after that edge. With `glb_en`=0, or without the strobe, `irq_take` stays 0.
- R3: Source i takes part in arbitration when `irq_req[i]` and `irq_en[i]` are both 1. Its level is `irq_prio[2i+1:2i]`. The winner is the participant with the highest level. A tie goes to the lowest index. The index order is INT0=0, Timer0=1, INT1=2, Timer1=3, Serial=4, Timer2=5, PCA=6.
- R4: On a take, `vec_addr` becomes 0xFF0003 + 8*i, where i is the winner's index. It then holds that value until the next take. Its upper byte is always 0xFF.
- R5: A winner is accepted only when no level is in service, or when its level is strictly greater than the highest level in service.
- R6: A take sets bit L of `lvl_busy`, where L is the winner's level. `act_level` shows the highest set bit of `lvl_busy`, or 0 when none is set.
- R7: A cycle with `ret_stb`=1 clears only the highest set bit of `lvl_busy`. When no bit is set, it has no effect.
- R8: When `ret_stb` and `insn_bnd` are both 1 in the same cycle, the return is performed and no interrupt is taken in that cycle.
- R9: A source whose enable bit is 0 is never taken, whatever its request and level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 7 | Request line per source |
| irq_en | input | 7 | Enable per source |
| irq_prio | input | 14 | Two-bit level per source, source i at bits 2i+1:2i |
| glb_en | input | 1 | Global interrupt enable |
| insn_bnd | input | 1 | Instruction-boundary strobe |
| ret_stb | input | 1 | Return-from-interrupt strobe |
| irq_take | output | 1 | One-cycle pulse: an interrupt was taken |
| vec_addr | output | 24 | Vector address of the last taken source |
| act_level | output | 2 | Highest level now in service |
| lvl_busy | output | 4 | In-service flag per level |

## Verification
A wrong in-service state appears on `lvl_busy` and `act_level` in the cycle after the take or return that corrupts it. It shows up again one strobe later as an `irq_take` that should have been refused, or one that is missing.

The stimulus nests three levels that arrive together. It then unwinds the nest one return at a time, checking after each return that only the top flag cleared. Finally it shows that a level-0 source is accepted again afterwards, which is the failure a stuck flag would cause.

Tied levels, disabled sources, a withheld global enable and a return that coincides with a boundary strobe each have a step of their own. After each such step the bench checks the vector and the flags.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int          NSRC      = 7,
  parameter int          ADDR_W    = 24,
  parameter logic [23:0] VEC_RESET = 24'hFF0000,
  parameter logic [23:0] VEC_BASE  = 24'hFF0003,
  parameter int          VEC_STEP  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     irq_req,
  input  logic [NSRC-1:0]     irq_en,
  input  logic [2*NSRC-1:0]   irq_prio,
  input  logic                glb_en,
  input  logic                insn_bnd,
  input  logic                ret_stb,
  output logic                irq_take,
  output logic [ADDR_W-1:0]   vec_addr,
  output logic [1:0]          act_level,
  output logic [3:0]          lvl_busy
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]  cand;
  logic             win_vld;
  logic [1:0]       win_lvl;
  logic [IDX_W-1:0] win_idx;
  logic [1:0]       top_lvl;
  logic             any_busy;
  logic             accept;

  assign cand     = irq_req & irq_en;
  assign any_busy = |lvl_busy;

  always_comb begin
    win_vld = 1'b0;
    win_lvl = 2'd0;
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i] && (!win_vld || irq_prio[2*i +: 2] >= win_lvl)) begin
        win_vld = 1'b1;
        win_lvl = irq_prio[2*i +: 2];
        win_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    top_lvl = 2'd0;
    for (int l = 0; l < 4; l++)
      if (lvl_busy[l]) top_lvl = 2'(l);
  end

  assign accept = insn_bnd && glb_en && !ret_stb && win_vld &&
                  (!any_busy || win_lvl > top_lvl);

  assign act_level = top_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_take <= 1'b0;
      lvl_busy <= 4'b0000;
      vec_addr <= ADDR_W'(VEC_RESET);
    end else begin
      irq_take <= accept;
      if (ret_stb) begin
        if (any_busy) lvl_busy[top_lvl] <= 1'b0;
      end else if (accept) begin
        lvl_busy[win_lvl] <= 1'b1;
        vec_addr <= ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(win_idx);
      end
    end
  end
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glb_en,
  input logic              insn_bnd,
  input logic              ret_stb,
  input logic              irq_take,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [1:0]        act_level,
  input logic [3:0]        lvl_busy
);
  assert_take_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(insn_bnd && glb_en && !ret_stb));

  assert_take_adds_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $countones(lvl_busy) == $countones($past(lvl_busy)) + 1);

  assert_strict_preempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> ($past(lvl_busy) == 4'b0000) || (act_level > $past(act_level)));

  assert_ret_drops_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ret_stb) && $past(lvl_busy) != 4'b0000) |->
      ($countones(lvl_busy) + 1 == $countones($past(lvl_busy))) &&
      ((lvl_busy & ~$past(lvl_busy)) == 4'b0000));

  assert_vec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_take |-> $stable(vec_addr));

  assert_vec_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr[ADDR_W-1 -: 8] == 8'hFF);
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .insn_bnd(insn_bnd),
  .ret_stb(ret_stb), .irq_take(irq_take), .vec_addr(vec_addr),
  .act_level(act_level), .lvl_busy(lvl_busy)
);

// File: tb/irq_nest_ctrl_tb_top.sv
module irq_nest_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  irq_req = '0;
  logic [6:0]  irq_en = '0;
  logic [13:0] irq_prio = '0;
  logic        glb_en = 1'b0;
  logic        insn_bnd = 1'b0;
  logic        ret_stb = 1'b0;
  logic        irq_take;
  logic [23:0] vec_addr;
  logic [1:0]  act_level;
  logic [3:0]  lvl_busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_nest_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .irq_prio(irq_prio), .glb_en(glb_en), .insn_bnd(insn_bnd),
    .ret_stb(ret_stb), .irq_take(irq_take), .vec_addr(vec_addr),
    .act_level(act_level), .lvl_busy(lvl_busy)
  );

  typedef struct packed {
    logic [6:0]  req;
    logic [6:0]  en;
    logic [13:0] prio;
    logic        gen;
    logic        bnd;
    logic        ret;
    logic        take;
    logic [23:0] vec;
    logic [3:0]  busy;
    logic [1:0]  lvl;
    logic [3:0]  rq;
  } step_t;

  // P = 14'h1563: INT0 level 3, INT1 level 2, Timer1/Serial/Timer2/PCA level 1, Timer0 level 0
  localparam int NSTEP = 21;
  localparam step_t TBL [NSTEP] = '{
    '{7'h00, 7'h7F, 14'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 24'hFF0000, 4'h0, 2'd0, 4'd2}, // R2 nothing pending
    '{7'h10, 7'h7F, 14'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 24'hFF0023, 4'h1, 2'd0, 4'd4}, // R4 Serial vector
    '{7'h10, 7'h7F, 14'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 24'hFF0023, 4'h1, 2'd0, 4'd5}, // R5 equal level refused
    '{7'h78, 7'h7F, 14'h1563, 1'b1, 1'b1, 1'b0, 1'b1, 24'hFF001B, 4'h3, 2'd1, 4'd3}, // R3 tie -> Timer1
    '{7'h70, 7'h7F, 14'h1563, 1'b1, 1'b1, 1'b0, 1'b0, 24'hFF001B, 4'h3, 2'd1, 4'd5}, // R5
    '{7'h05, 7'h7F, 14'h1563, 1'b1, 1'b1, 1'b0, 1'b1, 24'hFF0003, 4'hB, 2'd3, 4'd6}, // R6 level 3 wins
    '{7'h04, 7'h7F, 14'h1563, 1'b1, 1'b1, 1'b0, 1'b0, 24'hFF0003, 4'hB, 2'd3, 4'd5}, // R5 level 2 waits
    '{7'h04, 7'h7F, 14'h1563, 1'b1, 1'b0, 1'b1, 1'b0, 24'hFF0003, 4'h3, 2'd1, 4'd7}, // R7
    '{7'h04, 7'h7F, 14'h1563, 1'b1, 1'b1, 1'b0, 1'b1, 24'hFF0013, 4'h7, 2'd2, 4'd6}, // R6 three deep
    '{7'h00, 7'h7F, 14'h1563, 1'b1, 1'b0, 1'b1, 1'b0, 24'hFF0013, 4'h3, 2'd1, 4'd7}, // R7
    '{7'h00, 7'h7F, 14'h1563, 1'b1, 1'b0, 1'b1, 1'b0, 24'hFF0013, 4'h1, 2'd0, 4'd7}, // R7
    '{7'h00, 7'h7F, 14'h1563, 1'b1, 1'b0, 1'b1, 1'b0, 24'hFF0013, 4'h0, 2'd0, 4'd7}, // R7
    '{7'h10, 7'h7F, 14'h1563, 1'b0, 1'b1, 1'b0, 1'b0, 24'hFF0013, 4'h0, 2'd0, 4'd2}, // R2 global off
    '{7'h10, 7'h6F, 14'h1563, 1'b1, 1'b1, 1'b0, 1'b0, 24'hFF0013, 4'h0, 2'd0, 4'd9}, // R9 disabled
    '{7'h10, 7'h7F, 14'h1563, 1'b1, 1'b0, 1'b0, 1'b0, 24'hFF0013, 4'h0, 2'd0, 4'd2}, // R2 no strobe
    '{7'h10, 7'h7F, 14'h1563, 1'b1, 1'b1, 1'b1, 1'b0, 24'hFF0013, 4'h0, 2'd0, 4'd8}, // R8
    '{7'h10, 7'h7F, 14'h1563, 1'b1, 1'b1, 1'b0, 1'b1, 24'hFF0023, 4'h2, 2'd1, 4'd6}, // R6
    '{7'h02, 7'h7F, 14'h1563, 1'b1, 1'b1, 1'b0, 1'b0, 24'hFF0023, 4'h2, 2'd1, 4'd5}, // R5
    '{7'h02, 7'h7F, 14'h1563, 1'b1, 1'b0, 1'b1, 1'b0, 24'hFF0023, 4'h0, 2'd0, 4'd7}, // R7
    '{7'h02, 7'h7F, 14'h1563, 1'b1, 1'b1, 1'b0, 1'b1, 24'hFF000B, 4'h1, 2'd0, 4'd6}, // R6 level 0 again
    '{7'h00, 7'h7F, 14'h1563, 1'b1, 1'b0, 1'b1, 1'b0, 24'hFF000B, 4'h0, 2'd0, 4'd7}  // R7
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_reset();
    check("R1 take", 32'(irq_take), 32'h0);
    check("R1 busy", 32'(lvl_busy), 32'h0);
    check("R1 level", 32'(act_level), 32'h0);
    check("R1 vector", 32'(vec_addr), 32'hFF0000);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    check_reset();
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < NSTEP; s++) begin
      @(negedge clk);
      irq_req  = TBL[s].req;
      irq_en   = TBL[s].en;
      irq_prio = TBL[s].prio;
      glb_en   = TBL[s].gen;
      insn_bnd = TBL[s].bnd;
      ret_stb  = TBL[s].ret;
      @(posedge clk);
      #1;
      check($sformatf("R%0d step%0d take", TBL[s].rq, s), 32'(irq_take), 32'(TBL[s].take));
      check($sformatf("R%0d step%0d vec", TBL[s].rq, s), 32'(vec_addr), 32'(TBL[s].vec));
      check($sformatf("R%0d step%0d busy", TBL[s].rq, s), 32'(lvl_busy), 32'(TBL[s].busy));
      check($sformatf("R%0d step%0d level", TBL[s].rq, s), 32'(act_level), 32'(TBL[s].lvl));
    end
    // R2: pulse lasts one cycle even with the strobe held off
    @(negedge clk);
    irq_req = 7'h01; insn_bnd = 1'b1; ret_stb = 1'b0;
    @(posedge clk); #1;
    check("R2 take INT0", 32'(irq_take), 32'h1);
    @(negedge clk);
    insn_bnd = 1'b0;
    @(posedge clk); #1;
    check("R2 pulse width", 32'(irq_take), 32'h0);
    check("R6 busy level3", 32'(lvl_busy), 32'h8);
    // R1: reset mid-service
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset();
    @(negedge clk);
    rst_n = 1'b1;
    irq_req = '0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule